// File: doc/BRIEF.md
# Supply Monitor Interrupt Controller

This block is the digital half of a supply-voltage supervisor inside a microcontroller. Software programs it through one 8-bit control/status register on a plain CPU register bus, which has an address, a write strobe, write data and combinational read data. The register drives an enable and a 2-bit threshold code to an external analog comparator. The block also reports the comparator's conditioned output back to software.

The comparator output is asynchronous to the block clock. It passes through a two-flop synchronizer and then a stable-level filter, which accepts a new level only after it has held for `FILT_N` cycles. The filtered level appears as a read-only status bit and drives a sticky low-supply flag. The hardware sets the flag while the monitor is enabled and the supply is low, and software cannot clear it during that time. The flag clears itself only after the supply has stayed good without a break for `HOLD_CYC` cycles, and any accepted dip restarts that count. The interrupt request is the flag gated by an external interrupt-enable input.

Top module: `supmon_ctrl`

## Requirements
- R1: Reset is synchronous and active-low. After reset, the register at address `REG_ADDR` reads 0xDE. Any other address reads 0x00.
- R2: Bit 6 of the register is read-only and reads the filtered comparator level. After a change at `cmp_in`, bit 6 shows the new level from the (FILT_N+2)-th rising clock edge on.
- R3: A level on `cmp_in` that lasts fewer than FILT_N cycles changes neither bit 6 nor the flag. A level that lasts exactly FILT_N cycles is accepted.
- R4: Bits 4:3 hold a writable threshold code that drives `trip_sel` unchanged. The code 3 selects the lowest threshold and the code 0 the highest. Bit 0 is a writable enable that drives `mon_en`.
- R5: While enabled, a filtered-low comparator sets the flag (bit 5) one clock edge after bit 6 falls.
- R6: A write of 0 to bit 5 has no effect while the filtered comparator is low. While it is high, a write to bit 5 loads the written value.
- R7: After the filtered comparator rises with the flag set, the flag stays 1 for HOLD_CYC edges and clears on the next one.
- R8: A filtered dip low during the hold time restarts the hold count. The flag then clears HOLD_CYC edges after the final rise.
- R9: While the enable bit is 0, the flag is held at 0, even with the comparator low and even when software writes a 1 to it.
- R10: `irq` equals the flag ANDed with `irq_en`.
- R11: Bits 7, 2 and 1 always read 1, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | ADDR_W | Register bus address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from address |
| cmp_in | input | 1 | Raw comparator output, 1 = supply good |
| irq_en | input | 1 | External interrupt enable |
| trip_sel | output | 2 | Threshold code to comparator |
| mon_en | output | 1 | Comparator enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a hold count interrupted part way through. The dip has to be long enough to pass the filter and short enough that the flag is still set when the supply recovers. The bench times that dip from the first rise and then counts the edges from the second rise to the exact cycle the flag clears. Glitch widths from 1 to FILT_N are swept one at a time. At each width the bench watches bit 6 on every cycle and then checks the flag, so the filter threshold is found at its exact boundary.

// File: rtl/supmon_pkg.sv
// Package: register field positions and the power-on image of the
// supply monitor control/status register. Assumes an 8-bit register.
package supmon_pkg;
    localparam int REG_W     = 8;
    localparam int BIT_STAT  = 6;
    localparam int BIT_FLAG  = 5;
    localparam int BIT_TRIPH = 4;
    localparam int BIT_TRIPL = 3;
    localparam int BIT_EN    = 0;
    localparam logic [1:0] TRIP_RST = 2'b11;
    localparam logic [REG_W-1:0] REG_RST = 8'hDE;
endpackage

// File: rtl/supmon_deglitch.sv
// Synchronizer plus stable-level filter for the comparator output.
// Assumes FILT_N >= 2. The output takes a new level only after the
// synchronized input has differed from it for FILT_N consecutive cycles.
module supmon_deglitch #(
    parameter int   FILT_N  = 4,
    parameter logic RST_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl_out
);
    localparam int CW = $clog2(FILT_N + 1);

    logic          sync_a, sync_b;
    logic [CW-1:0] run_cnt;

    // Two-flop synchronizer for the asynchronous comparator level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= RST_LVL;
            sync_b <= RST_LVL;
        end else begin
            sync_a <= async_in;
            sync_b <= sync_a;
        end
    end

    // Count cycles of disagreement; adopt the new level after FILT_N of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_out <= RST_LVL;
            run_cnt <= '0;
        end else if (sync_b != lvl_out) begin
            if (run_cnt == CW'(FILT_N - 1)) begin
                lvl_out <= sync_b;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end else begin
            run_cnt <= '0;
        end
    end

    p_filt_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl_out) |-> (lvl_out == $past(sync_b)));
    p_filt_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt < CW'(FILT_N));
endmodule

// File: rtl/supmon_hold_timer.sv
// Hold timer: counts cycles while 'run' is high and pulses 'expire' on the
// HOLD_CYC-th cycle of an unbroken run. Any low cycle on 'run' restarts it.
module supmon_hold_timer #(
    parameter int HOLD_CYC = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int TW = $clog2(HOLD_CYC + 1);
    localparam logic [TW-1:0] LAST = TW'(HOLD_CYC - 1);

    logic [TW-1:0] cnt;

    assign expire = run && (cnt == LAST);

    // Advance while running, wrap on expiry, clear whenever run drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || expire) cnt <= '0;
        else                          cnt <= cnt + 1'b1;
    end

    p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/supmon_ctrl.sv
// Supply monitor control: one control/status register, a conditioned
// comparator input and a sticky low-supply flag with timed release.
// Assumes a single-cycle write strobe and combinational reads.
module supmon_ctrl
    import supmon_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'hDF,
    parameter int          FILT_N   = 4,
    parameter int          HOLD_CYC = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              cmp_in,
    input  logic              irq_en,
    output logic [1:0]        trip_sel,
    output logic              mon_en,
    output logic              irq
);
    logic       cmp_ok;
    logic       flag_q;
    logic       en_q;
    logic [1:0] trip_q;
    logic       expire;
    logic       wr_hit;
    logic       unused_wbits;

    assign wr_hit       = reg_wr && (reg_addr == REG_ADDR);
    assign unused_wbits = ^{reg_wdata[7:6], reg_wdata[2:1]};

    supmon_deglitch #(.FILT_N(FILT_N), .RST_LVL(1'b1)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cmp_in),
        .lvl_out  (cmp_ok)
    );

    supmon_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (en_q && flag_q && cmp_ok),
        .expire (expire)
    );

    // Writable configuration fields: threshold code and monitor enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trip_q <= TRIP_RST;
            en_q   <= 1'b0;
        end else if (wr_hit) begin
            trip_q <= reg_wdata[BIT_TRIPH:BIT_TRIPL];
            en_q   <= reg_wdata[BIT_EN];
        end
    end

    // Sticky flag: off when disabled, forced by low supply, released by timer.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (!en_q)  flag_q <= 1'b0;
        else if (!cmp_ok) flag_q <= 1'b1;
        else if (expire) flag_q <= 1'b0;
        else if (wr_hit) flag_q <= reg_wdata[BIT_FLAG];
    end

    // Register image; reserved bits read as ones.
    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == REG_ADDR)
            reg_rdata = {1'b1, cmp_ok, flag_q, trip_q, 2'b11, en_q};
    end

    assign trip_sel = trip_q;
    assign mon_en   = en_q;
    assign irq      = flag_q && irq_en;

    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !cmp_ok) |=> flag_q);
    p_hold_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !cmp_ok && wr_hit && reg_wdata[BIT_EN]) |=> flag_q);
    p_flag_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> ($past(expire) || !$past(en_q) ||
                           $past(wr_hit && !reg_wdata[BIT_FLAG])));
    p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !flag_q);
endmodule

// File: tb/test_supmon_ctrl.sv
`timescale 1ns/1ps
module test_supmon_ctrl;
    localparam int FN   = 4;
    localparam int HOLD = 16;
    localparam logic [7:0] RA = 8'hDF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = RA;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       cmp_in = 1'b1;
    logic       irq_en = 1'b0;
    logic [1:0] trip_sel;
    logic       mon_en;
    logic       irq;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;

    supmon_ctrl #(.ADDR_W(8), .REG_ADDR(RA), .FILT_N(FN), .HOLD_CYC(HOLD)) i_supmon_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_in(cmp_in),
        .irq_en(irq_en), .trip_sel(trip_sel), .mon_en(mon_en), .irq(irq));

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1: reset image and foreign address
        chk(reg_rdata, 8'hDE, "R1 reset value");
        chk(mon_en, 0, "R1 mon_en reset");
        chk(trip_sel, 3, "R1 trip reset");
        reg_addr = 8'h10; tick(1);
        chk(reg_rdata, 0, "R1 other address");
        reg_addr = RA;

        // R4, R11: sweep threshold code and enable
        for (int t = 0; t < 4; t++) begin
            for (int e = 0; e < 2; e++) begin
                wr(8'((t << 3) | e));
                chk(trip_sel, t, "R4 trip_sel");
                chk(mon_en, e, "R4 mon_en");
                chk(reg_rdata, 8'hC6 | (t << 3) | e, "R11 readback");
            end
        end

        // R2, R5, R10: enable at threshold 0, drop supply, time the response
        wr(8'h01);
        @(negedge clk); cmp_in = 1'b0;
        tick(FN + 1);
        chk(reg_rdata[6], 1, "R2 status before latency");
        tick(1);
        chk(reg_rdata[6], 0, "R2 status at latency");
        chk(reg_rdata[5], 0, "R5 flag one edge later");
        tick(1);
        chk(reg_rdata[5], 1, "R5 flag set");
        chk(irq, 0, "R10 irq gated off");
        irq_en = 1'b1; tick(1);
        chk(irq, 1, "R10 irq passes");

        // R6: clearing while low is ignored
        wr(8'h01);
        chk(reg_rdata[5], 1, "R6 write 0 while low");

        // R7: release after hold time
        @(negedge clk); cmp_in = 1'b1;
        tick(FN + 2);
        chk(reg_rdata[6], 1, "R2 status rises");
        tick(HOLD - 1);
        chk(reg_rdata[5], 1, "R7 flag at last hold cycle");
        tick(1);
        chk(reg_rdata[5], 0, "R7 flag released");
        chk(irq, 0, "R10 irq follows flag");

        // R6: writes while good are loaded
        wr(8'h21);
        chk(reg_rdata[5], 1, "R6 write 1 while good");
        wr(8'h01);
        chk(reg_rdata[5], 0, "R6 write 0 while good");

        // R3: glitch width sweep
        for (int w = 1; w <= FN; w++) begin
            int seen_low = 0;
            @(negedge clk); cmp_in = 1'b0;
            tick(w);
            cmp_in = 1'b1;
            for (int k = 0; k < 2 * FN + 4; k++) begin
                @(negedge clk);
                if (reg_rdata[6] == 1'b0) seen_low = 1;
            end
            chk(seen_low, (w >= FN) ? 1 : 0, "R3 status glitch");
            chk(reg_rdata[5], (w >= FN) ? 1 : 0, "R3 flag glitch");
        end
        tick(HOLD + 2);
        chk(reg_rdata[5], 0, "R3 flag recovered");

        // R8: dip during hold restarts the count
        @(negedge clk); cmp_in = 1'b0;
        tick(FN + 4);
        cmp_in = 1'b1;
        tick(FN + 2 + HOLD / 2);
        cmp_in = 1'b0;
        tick(FN + 2);
        cmp_in = 1'b1;
        tick(FN + 1 + HOLD);
        chk(reg_rdata[5], 1, "R8 flag held after restart");
        tick(1);
        chk(reg_rdata[5], 0, "R8 flag clears after full hold");

        // R9: disabled monitor keeps the flag at 0
        wr(8'h18);
        @(negedge clk); cmp_in = 1'b0;
        tick(FN + 4);
        chk(reg_rdata[5], 0, "R9 disabled low supply");
        wr(8'h38);
        chk(reg_rdata[5], 0, "R9 disabled write 1");
        chk(irq, 0, "R9 irq disabled");
        wr(8'h19);
        tick(1);
        chk(reg_rdata[5], 1, "R9 enable while low sets");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule